// File: doc/BRIEF.md
# Binary Butterfly Stage Switch

This block is the two-in, two-out switching element from which a binary butterfly is built, one column of such elements per stage. Words arrive on two input links and leave on two output links. Each link is a ready/acknowledge word channel. A packet is one header word followed by a number of payload words. The header carries the destination index and the payload length. The switch looks at a single bit of the destination, chosen by its stage parameter. If that bit equals the switch's own level bit, the packet takes the straight output (port 0), which leads to the same level in the next stage. Otherwise it takes the oblique output (port 1), which leads to the level whose index differs in that one bit.

An output is claimed when a header passes through it. It then stays tied to that input until the stated number of payload words has gone by, so packets never interleave on an output. Packets bound for different outputs move in the same cycle. When both inputs present headers for the same free output, a per-output round-robin pointer picks the winner. The loser waits, because its acknowledge stays low. Each output has a two-word buffer, so one word per cycle flows when the downstream side keeps accepting.

Top module: `bfly_switch`

## Requirements
- R1: After reset both out_rdy bits are 0, and no in_ack bit rises while in_rdy is 0.
- R2: A header's destination sits in its low DEST_W bits and its payload length in the next LEN_W bits. If destination bit STAGE equals LEVEL_BIT the packet leaves on output 0, otherwise on output 1.
- R3: Every accepted word leaves unchanged on the chosen output. Packets from one input to one output keep their order.
- R4: After a header with nonzero length is accepted, its output takes no word from the other input until all the packet's payload words have passed.
- R5: Two headers that pick different free outputs are both acknowledged in the same cycle.
- R6: If both inputs present headers for the same free output in one cycle, the input named by that output's pointer wins. The pointer is 0 after reset and moves to the other input after each header grant on that output.
- R7: Each output buffer holds BUF_DEPTH words. When it is full, in_ack toward it stays 0. A word leaving in a cycle does not free space for a word arriving in that same cycle. No word is lost.
- R8: A header whose length is 0 releases its output at once, so another header can claim it in the next cycle.
- R9: With out_ack held at 1, a packet flows at one word per cycle with no gap.
- R10: While out_rdy is 1 and out_ack is 0, out_rdy stays 1 and out_word holds its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_rdy | input | 2 | Word present on each input link |
| in_word | input | 2 x WORD_W | Word on each input link |
| in_ack | output | 2 | Word taken from each input link this cycle |
| out_rdy | output | 2 | Word present on output 0 (straight) and output 1 (oblique) |
| out_word | output | 2 x WORD_W | Word on each output link |
| out_ack | input | 2 | Downstream takes the output word this cycle |

## Verification
The bench uses WORD_W 16, DEST_W 3, LEN_W 3, STAGE 1, LEVEL_BIT 1 and BUF_DEPTH 2. With a two-word buffer, a full output is reached after two stalled cycles. With a three-bit length field, both zero-length and maximum-length packets appear often in random traffic. With stage 1 and level bit 1, destinations 2, 3, 6 and 7 must go straight and the rest oblique. The spare upper header bits carry a source tag and sequence number, so each output stream can be traced back to its sender packet by packet.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int NUM_LINKS = 2;

    typedef enum logic {
        PORT_STRAIGHT = 1'b0,
        PORT_OBLIQUE  = 1'b1
    } bfly_port_e;
endpackage

// File: rtl/bfly_route.sv
module bfly_route #(
    parameter int WORD_W    = 16,
    parameter int DEST_W    = 3,
    parameter int LEN_W     = 3,
    parameter int STAGE     = 1,
    parameter bit LEVEL_BIT = 1'b1
) (
    input  logic [WORD_W-1:0]     hdr,
    output bfly_pkg::bfly_port_e  port,
    output logic [LEN_W-1:0]      len
);
    logic [DEST_W-1:0] dest;

    always_comb begin
        dest = hdr[DEST_W-1:0];
        len  = hdr[DEST_W +: LEN_W];
        port = (dest[STAGE] == LEVEL_BIT) ? bfly_pkg::PORT_STRAIGHT
                                          : bfly_pkg::PORT_OBLIQUE;
    end
endmodule

// File: rtl/bfly_link_buf.sv
module bfly_link_buf #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    output logic              space,
    output logic              out_rdy,
    output logic [WORD_W-1:0] out_word,
    input  logic              out_ack
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } buf_t;

    buf_t st_d, st_q;
    logic pop;

    always_comb begin
        st_d     = st_q;
        space    = (st_q.cnt < CNT_W'(DEPTH));
        out_rdy  = (st_q.cnt != '0);
        out_word = st_q.mem[st_q.rd];
        pop      = out_rdy && out_ack;

        if (push) begin
            st_d.mem[st_q.wr] = push_word;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bfly_switch.sv
module bfly_switch #(
    parameter int WORD_W    = 16,
    parameter int DEST_W    = 3,
    parameter int LEN_W     = 3,
    parameter int STAGE     = 1,
    parameter bit LEVEL_BIT = 1'b1,
    parameter int BUF_DEPTH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             in_rdy,
    input  logic [1:0][WORD_W-1:0] in_word,
    output logic [1:0]             in_ack,
    output logic [1:0]             out_rdy,
    output logic [1:0][WORD_W-1:0] out_word,
    input  logic [1:0]             out_ack
);
    import bfly_pkg::*;

    localparam int NL = NUM_LINKS;

    typedef struct packed {
        logic             busy;
        logic             owner;
        logic [LEN_W-1:0] remain;
    } hold_t;

    typedef struct packed {
        hold_t [NL-1:0] hold;
        logic  [NL-1:0] rr;
    } sw_t;

    sw_t st_d, st_q;

    bfly_port_e              dst_port [NL];
    logic [NL-1:0][LEN_W-1:0] hdr_len;
    logic [NL-1:0]            held;
    logic [NL-1:0]            win;
    logic [NL-1:0]            live;
    logic [NL-1:0]            push;
    logic [NL-1:0]            space;
    logic [NL-1:0][WORD_W-1:0] buf_word;

    for (genvar gi = 0; gi < NL; gi++) begin : g_in
        bfly_route #(
            .WORD_W   (WORD_W),
            .DEST_W   (DEST_W),
            .LEN_W    (LEN_W),
            .STAGE    (STAGE),
            .LEVEL_BIT(LEVEL_BIT)
        ) u_route (
            .hdr (in_word[gi]),
            .port(dst_port[gi]),
            .len (hdr_len[gi])
        );
    end

    for (genvar go = 0; go < NL; go++) begin : g_out
        bfly_link_buf #(
            .WORD_W(WORD_W),
            .DEPTH (BUF_DEPTH)
        ) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[go]),
            .push_word(buf_word[go]),
            .space    (space[go]),
            .out_rdy  (out_rdy[go]),
            .out_word (out_word[go]),
            .out_ack  (out_ack[go])
        );
    end

    always_comb begin
        st_d     = st_q;
        in_ack   = '0;
        push     = '0;
        win      = '0;
        live     = '0;
        buf_word = '0;
        held     = '0;

        // an input is mid-packet when some output is tied to it
        for (int o = 0; o < NL; o++) begin
            if (st_q.hold[o].busy) held[st_q.hold[o].owner] = 1'b1;
        end

        for (int o = 0; o < NL; o++) begin
            logic req0, req1;
            req0 = in_rdy[0] && !held[0] && ((dst_port[0] == PORT_OBLIQUE) == (o == 1));
            req1 = in_rdy[1] && !held[1] && ((dst_port[1] == PORT_OBLIQUE) == (o == 1));

            if (st_q.hold[o].busy) begin
                win[o]  = st_q.hold[o].owner;
                live[o] = in_rdy[st_q.hold[o].owner];
            end else if (req0 && req1) begin
                win[o]  = st_q.rr[o];
                live[o] = 1'b1;
            end else begin
                win[o]  = req1;
                live[o] = req0 || req1;
            end

            push[o]     = live[o] && space[o];
            buf_word[o] = in_word[win[o]];
            if (push[o]) in_ack[win[o]] = 1'b1;

            if (push[o]) begin
                if (st_q.hold[o].busy) begin
                    st_d.hold[o].remain = st_q.hold[o].remain - 1'b1;
                    if (st_q.hold[o].remain == LEN_W'(1)) st_d.hold[o].busy = 1'b0;
                end else begin
                    st_d.rr[o] = ~win[o];
                    if (hdr_len[win[o]] != '0) begin
                        st_d.hold[o].busy   = 1'b1;
                        st_d.hold[o].owner  = win[o];
                        st_d.hold[o].remain = hdr_len[win[o]];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bfly_switch_chk.sv
module bfly_switch_chk #(
    parameter int WORD_W    = 16,
    parameter int BUF_DEPTH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             in_rdy,
    input logic [1:0]             in_ack,
    input logic [1:0]             out_rdy,
    input logic [1:0][WORD_W-1:0] out_word,
    input logic [1:0]             out_ack
);
    localparam int OCC_W = $clog2(2 * BUF_DEPTH + 1) + 2;

    logic [OCC_W-1:0] occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + OCC_W'($countones(in_rdy & in_ack))
                                   - OCC_W'($countones(out_rdy & out_ack));
    end

    assert_hold_out0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy[0] && !out_ack[0]) |=> (out_rdy[0] && $stable(out_word[0])));

    assert_hold_out1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy[1] && !out_ack[1]) |=> (out_rdy[1] && $stable(out_word[1])));

    assert_ack_needs_rdy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_ack & ~in_rdy) == 2'b00));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q <= OCC_W'(2 * BUF_DEPTH)));

    assert_empty_no_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (out_rdy == 2'b00));
endmodule

bind bfly_switch bfly_switch_chk #(
    .WORD_W   (WORD_W),
    .BUF_DEPTH(BUF_DEPTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_rdy  (in_rdy),
    .in_ack  (in_ack),
    .out_rdy (out_rdy),
    .out_word(out_word),
    .out_ack (out_ack)
);

// File: tb/bfly_switch_test.sv
module bfly_switch_test;
    localparam int CLK_P     = 10;
    localparam int WORD_W    = 16;
    localparam int STAGE     = 1;
    localparam bit LEVEL_BIT = 1'b1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [1:0]             in_rdy = '0;
    logic [1:0][WORD_W-1:0] in_word = '0;
    logic [1:0]             in_ack;
    logic [1:0]             out_rdy;
    logic [1:0][WORD_W-1:0] out_word;
    logic [1:0]             out_ack = '0;

    int vectors = 0;
    int errors  = 0;
    bit rand_on = 1'b0;
    bit done    = 1'b0;

    logic [WORD_W-1:0] exp_q [4][$];
    int  rem [2];
    bit  in_pkt [2];
    int  cur_src [2];

    always #(CLK_P/2) clk = ~clk;

    bfly_switch #(
        .WORD_W(WORD_W), .DEST_W(3), .LEN_W(3),
        .STAGE(STAGE), .LEVEL_BIT(LEVEL_BIT), .BUF_DEPTH(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .in_word(in_word),
        .in_ack(in_ack), .out_rdy(out_rdy), .out_word(out_word), .out_ack(out_ack)
    );

    // header: [2:0] dest, [5:3] length, [6] source tag, [15:7] sequence
    function automatic logic [WORD_W-1:0] mk_hdr(int src, int dest, int len, int seq);
        return {9'(seq), 1'(src), 3'(len), 3'(dest)};
    endfunction

    function automatic int exp_port(logic [WORD_W-1:0] h);
        return (h[STAGE] == LEVEL_BIT) ? 0 : 1;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // queue a whole packet for the model; returns its words
    task automatic plan_pkt(int src, int dest, int len, int seq,
                            output logic [WORD_W-1:0] w [8]);
        int p;
        w[0] = mk_hdr(src, dest, len, seq);
        p = exp_port(w[0]);
        exp_q[src*2+p].push_back(w[0]);
        for (int k = 1; k <= len; k++) begin
            w[k] = WORD_W'($urandom);
            exp_q[src*2+p].push_back(w[k]);
        end
        for (int k = len + 1; k < 8; k++) w[k] = '0;
    endtask

    task automatic drive(bit r0, logic [WORD_W-1:0] w0, bit r1, logic [WORD_W-1:0] w1,
                         logic [1:0] oa);
        @(negedge clk);
        in_rdy     = {r1, r0};
        in_word[0] = w0;
        in_word[1] = w1;
        out_ack    = oa;
        #(CLK_P/2 - 1);
    endtask

    task automatic send_pkt(int i, int dest, int len, int seq);
        logic [WORD_W-1:0] w [8];
        plan_pkt(i, dest, len, seq, w);
        for (int k = 0; k <= len; k++) begin
            @(negedge clk);
            in_rdy[i]  = 1'b1;
            in_word[i] = w[k];
            #(CLK_P/2 - 1);
            while (!in_ack[i]) begin
                @(negedge clk);
                #(CLK_P/2 - 1);
            end
        end
        @(negedge clk);
        in_rdy[i] = 1'b0;
    endtask

    task automatic consume(int o, logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] e;
        int q;
        if (!in_pkt[o]) begin
            check(exp_port(w) == o, "R2 route", o, exp_port(w));
            cur_src[o] = int'(w[6]);
            q = cur_src[o]*2 + o;
            if (exp_q[q].size() == 0) begin
                check(1'b0, "R3 unexpected header", w, 0);
            end else begin
                e = exp_q[q].pop_front();
                check(w == e, "R3 header data", w, e);
            end
            rem[o]    = int'(w[5:3]);
            in_pkt[o] = (rem[o] != 0);
        end else begin
            q = cur_src[o]*2 + o;
            if (exp_q[q].size() == 0) begin
                check(1'b0, "R4 unexpected payload", w, 0);
            end else begin
                e = exp_q[q].pop_front();
                check(w == e, "R4 payload order", w, e);
            end
            rem[o]--;
            if (rem[o] == 0) in_pkt[o] = 1'b0;
        end
    endtask

    // output monitor
    initial begin
        in_pkt[0] = 0; in_pkt[1] = 0; rem[0] = 0; rem[1] = 0;
        forever begin
            @(negedge clk);
            #(CLK_P/2 - 1);
            for (int o = 0; o < 2; o++)
                if (rst_n && out_rdy[o] && out_ack[o]) consume(o, out_word[o]);
        end
    end

    // random downstream acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (rand_on) out_ack = {($urandom % 4) != 0, ($urandom % 4) != 0};
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [WORD_W-1:0] a [8], b [8], c [8];
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        drive(0, '0, 0, '0, 2'b11);
        check(out_rdy == 2'b00, "R1 out_rdy after reset", out_rdy, 0);
        check(in_ack == 2'b00, "R1 in_ack idle", in_ack, 0);

        // R6 / R8 contention on straight output with zero-length headers
        plan_pkt(0, 3'b010, 0, 1, a);
        plan_pkt(1, 3'b110, 0, 2, b);
        plan_pkt(0, 3'b011, 0, 3, c);
        drive(1, a[0], 1, b[0], 2'b11);
        check(in_ack == 2'b01, "R6 pointer starts at input 0", in_ack, 2'b01);
        drive(1, c[0], 1, b[0], 2'b11);
        check(in_ack == 2'b10, "R6 pointer moved to input 1 / R8 release", in_ack, 2'b10);
        drive(1, c[0], 0, '0, 2'b11);
        check(in_ack == 2'b01, "R8 next header claims freed output", in_ack, 2'b01);

        // R5 parallel forwarding
        plan_pkt(0, 3'b111, 0, 4, a);
        plan_pkt(1, 3'b001, 0, 5, b);
        drive(1, a[0], 1, b[0], 2'b11);
        check(in_ack == 2'b11, "R5 both outputs in one cycle", in_ack, 2'b11);

        // R4 hold for a multi-word packet
        plan_pkt(0, 3'b010, 2, 6, a);
        plan_pkt(1, 3'b010, 0, 7, b);
        drive(1, a[0], 0, '0, 2'b11);
        check(in_ack == 2'b01, "R4 header accepted", in_ack, 2'b01);
        drive(1, a[1], 1, b[0], 2'b11);
        check(in_ack == 2'b01, "R4 other input held off", in_ack, 2'b01);
        drive(1, a[2], 1, b[0], 2'b11);
        check(in_ack == 2'b01, "R4 other input held off on last word", in_ack, 2'b01);
        drive(0, '0, 1, b[0], 2'b11);
        check(in_ack == 2'b10, "R4 released after last payload", in_ack, 2'b10);
        repeat (4) drive(0, '0, 0, '0, 2'b11);

        // R7 back-pressure with a two-word buffer on the oblique output
        plan_pkt(0, 3'b000, 3, 8, a);
        drive(1, a[0], 0, '0, 2'b00);
        check(in_ack == 2'b01, "R7 first word into empty buffer", in_ack, 2'b01);
        drive(1, a[1], 0, '0, 2'b00);
        check(in_ack == 2'b01, "R7 second word fills buffer", in_ack, 2'b01);
        drive(1, a[2], 0, '0, 2'b00);
        check(in_ack == 2'b00, "R7 full buffer refuses", in_ack, 2'b00);
        drive(1, a[2], 0, '0, 2'b11);
        check(in_ack == 2'b00, "R7 same-cycle pop frees nothing", in_ack, 2'b00);
        drive(1, a[2], 0, '0, 2'b11);
        check(in_ack == 2'b01, "R7 space after drain", in_ack, 2'b01);
        drive(1, a[3], 0, '0, 2'b11);
        check(in_ack == 2'b01, "R7 last word", in_ack, 2'b01);
        repeat (4) drive(0, '0, 0, '0, 2'b11);

        // R9 full-rate flow
        plan_pkt(1, 3'b100, 7, 9, b);
        for (int k = 0; k <= 7; k++) begin
            drive(0, '0, 1, b[k], 2'b11);
            check(in_ack[1] == 1'b1, "R9 one word per cycle", in_ack, 2'b10);
        end
        repeat (4) drive(0, '0, 0, '0, 2'b11);

        // random traffic
        rand_on = 1'b1;
        fork
            begin
                for (int n = 0; n < 40; n++) begin
                    send_pkt(0, $urandom % 8, $urandom % 8, 100 + n);
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
            begin
                for (int n = 0; n < 40; n++) begin
                    send_pkt(1, $urandom % 8, $urandom % 8, 200 + n);
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
        join
        rand_on = 1'b0;
        @(negedge clk);
        out_ack = 2'b11;
        repeat (20) @(negedge clk);
        for (int q = 0; q < 4; q++)
            check(exp_q[q].size() == 0, "R3 all words delivered", exp_q[q].size(), 0);
        finish_run();
    end
endmodule